// File: doc/BRIEF.md
# Timer trigger output selector

This block chooses which internal timer event appears on the trigger outputs that a timer offers to other timers and to converters. A primary output is steered by a 3-bit select field. It can carry the update-generate pulse, the counter-enable level, the update event, the compare-match pulse or one of four compare reference levels.

A secondary output is steered by a 4-bit select field. It offers everything the primary offers, plus two further reference levels. It also offers pulses taken from edges of one compare reference, and pulses from the OR of edges on two references. A build parameter decides whether this secondary path exists. When it is left out, its select field keeps no state and reads back as zero, so software can detect whether the output is present.

Every output is registered once. Edge-derived pulses come from a registered copy of the reference levels, and each lasts exactly one clock.

Top module: `trgsel_top`

## Requirements
- R1: While reset is held, and in the first cycle after it, both trigger outputs are 0 and both select read-back fields are 0.
- R2: Primary codes 0, 1, 2 and 3 route `ev_ug`, `cnt_en`, `ev_upd` and `ev_cmp` respectively. The output shows the input one clock later.
- R3: Primary codes 4 to 7 route `oc_lvl[0]` to `oc_lvl[3]` respectively, one clock later.
- R4: A cycle with `cfg_wr` high loads both select fields at that clock edge. The read-back ports show them from then on, and they are held while `cfg_wr` is low. The output register at the write edge still uses the old code. The new code governs the output from the following edge onward.
- R5: Secondary codes 0 to 7 have the same meanings as the primary codes.
- R6: Secondary code 8 routes `oc_lvl[4]` and code 9 routes `oc_lvl[5]`, one clock later.
- R7: Secondary code 10 pulses on either edge of `oc_lvl[3]`. Code 11 pulses on either edge of `oc_lvl[5]`.
- R8: Secondary codes select these pulses. Code 12 gives rise of `oc_lvl[3]` OR rise of `oc_lvl[5]`. Code 13 gives rise of `oc_lvl[3]` OR fall of `oc_lvl[5]`. Code 14 gives rise of `oc_lvl[4]` OR rise of `oc_lvl[5]`. Code 15 gives rise of `oc_lvl[4]` OR fall of `oc_lvl[5]`. An edge is a change of the input between two consecutive clock samples.
- R9: A level that changes once and then holds gives one pulse of exactly one clock on an edge-derived output.
- R10: With `HAS_SEC` = 0, writes to the secondary field are ignored. `cfg_sec_rd` reads 0 and `trig_sec` stays 0, and the primary path behaves as in R2 to R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Load strobe for both select fields |
| cfg_pri_wdata | input | 3 | New primary select code |
| cfg_sec_wdata | input | 4 | New secondary select code |
| ev_ug | input | 1 | Software update-generate pulse |
| cnt_en | input | 1 | Counter enable level |
| ev_upd | input | 1 | Update event pulse |
| ev_cmp | input | 1 | Compare-match pulse |
| oc_lvl | input | 6 | Compare reference levels, bit k is reference k+1 |
| cfg_pri_rd | output | 3 | Primary select read-back |
| cfg_sec_rd | output | 4 | Secondary select read-back, 0 when absent |
| trig_pri | output | 1 | Primary trigger output |
| trig_sec | output | 1 | Secondary trigger output |

## Verification
The assertions assume the following about the inputs:
- All event and level inputs are synchronous to `clk`.
- A reference level can only change between samples.
- `oc_lvl` is low while reset is applied, so the registered copy and the input agree when reset is released.

The bench meets these assumptions by driving every input on the falling clock edge and by holding all inputs at zero during reset. It then sweeps every select code on the primary and secondary fields over an arithmetic stimulus pattern. Held-level sequences cover R9.

// File: rtl/trgsel_pkg.sv
package trgsel_pkg;

    localparam int PRI_W   = 3;
    localparam int SEC_W   = 4;
    localparam int NUM_REF = 6;

    typedef enum logic [3:0] {
        TS_UG     = 4'd0,
        TS_EN     = 4'd1,
        TS_UPD    = 4'd2,
        TS_CMP    = 4'd3,
        TS_LVL1   = 4'd4,
        TS_LVL2   = 4'd5,
        TS_LVL3   = 4'd6,
        TS_LVL4   = 4'd7,
        TS_LVL5   = 4'd8,
        TS_LVL6   = 4'd9,
        TS_EDG4   = 4'd10,
        TS_EDG6   = 4'd11,
        TS_R4_R6R = 4'd12,
        TS_R4_R6F = 4'd13,
        TS_R5_R6R = 4'd14,
        TS_R5_R6F = 4'd15
    } tsel_e;

    typedef struct packed {
        logic               ug;
        logic               en;
        logic               upd;
        logic               cmp;
        logic [NUM_REF-1:0] lvl;
        logic [NUM_REF-1:0] rise;
        logic [NUM_REF-1:0] fall;
    } evt_src_t;

    // Shared routing table; a 3-bit field is zero-extended before use.
    function automatic logic pick_src(input logic [3:0] code, input evt_src_t s);
        logic r;
        case (tsel_e'(code))
            TS_UG:     r = s.ug;
            TS_EN:     r = s.en;
            TS_UPD:    r = s.upd;
            TS_CMP:    r = s.cmp;
            TS_LVL1:   r = s.lvl[0];
            TS_LVL2:   r = s.lvl[1];
            TS_LVL3:   r = s.lvl[2];
            TS_LVL4:   r = s.lvl[3];
            TS_LVL5:   r = s.lvl[4];
            TS_LVL6:   r = s.lvl[5];
            TS_EDG4:   r = s.rise[3] | s.fall[3];
            TS_EDG6:   r = s.rise[5] | s.fall[5];
            TS_R4_R6R: r = s.rise[3] | s.rise[5];
            TS_R4_R6F: r = s.rise[3] | s.fall[5];
            TS_R5_R6R: r = s.rise[4] | s.rise[5];
            TS_R5_R6F: r = s.rise[4] | s.fall[5];
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/trgsel_cfg.sv
module trgsel_cfg
    import trgsel_pkg::*;
#(
    parameter bit HAS_SEC = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [PRI_W-1:0] pri_wdata,
    input  logic [SEC_W-1:0] sec_wdata,
    output logic [PRI_W-1:0] pri_sel,
    output logic [SEC_W-1:0] sec_sel
);

    typedef struct packed {
        logic [PRI_W-1:0] pri;
        logic [SEC_W-1:0] sec;
    } cfg_st_t;

    cfg_st_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            cfg_d.pri = pri_wdata;
            cfg_d.sec = HAS_SEC ? sec_wdata : '0;
        end
        if (!HAS_SEC) begin
            cfg_d.sec = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign pri_sel = cfg_q.pri;
    assign sec_sel = cfg_q.sec;

    p_pri_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (pri_sel == $past(pri_wdata)));

    p_pri_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(pri_sel));

    if (HAS_SEC) begin : g_sec_chk
        p_sec_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
            wr |=> (sec_sel == $past(sec_wdata)));
    end else begin : g_nosec_chk
        p_sec_absent_r10: assert property (@(posedge clk) disable iff (!rst_n)
            wr |=> (sec_sel == '0));
    end

endmodule

// File: rtl/trgsel_edge.sv
module trgsel_edge
    import trgsel_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REF-1:0] lvl_in,
    output logic [NUM_REF-1:0] rise,
    output logic [NUM_REF-1:0] fall
);

    typedef struct packed {
        logic [NUM_REF-1:0] lvl;
    } edg_st_t;

    edg_st_t edg_d, edg_q;

    always_comb begin
        edg_d     = edg_q;
        edg_d.lvl = lvl_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) edg_q <= '0;
        else        edg_q <= edg_d;
    end

    assign rise = lvl_in & ~edg_q.lvl;
    assign fall = ~lvl_in & edg_q.lvl;

    for (genvar k = 0; k < NUM_REF; k++) begin : g_chk
        p_rise_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
            rise[k] |=> !rise[k]);
        p_fall_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
            fall[k] |=> !fall[k]);
    end

endmodule

// File: rtl/trgsel_route.sv
module trgsel_route
    import trgsel_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  evt_src_t         src,
    output logic             trig
);

    typedef struct packed {
        logic trig;
    } rte_st_t;

    rte_st_t rte_d, rte_q;
    logic [3:0] code;

    assign code = 4'(sel);

    always_comb begin
        rte_d      = rte_q;
        rte_d.trig = pick_src(code, src);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rte_q <= '0;
        else        rte_q <= rte_d;
    end

    assign trig = rte_q.trig;

    p_en_route_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (code == 4'd1) |=> (trig == $past(src.en)));

    p_lvl1_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (code == 4'd4) |=> (trig == $past(src.lvl[0])));

    p_lvl6_route_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (code == 4'd9) |=> (trig == $past(src.lvl[5])));

    p_edge4_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (code == 4'd10) |=> (trig == $past(src.rise[3] | src.fall[3])));

    p_mix_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (code == 4'd15) |=> (trig == $past(src.rise[4] | src.fall[5])));

endmodule

// File: rtl/trgsel_top.sv
module trgsel_top
    import trgsel_pkg::*;
#(
    parameter bit HAS_SEC = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [PRI_W-1:0]   cfg_pri_wdata,
    input  logic [SEC_W-1:0]   cfg_sec_wdata,
    input  logic               ev_ug,
    input  logic               cnt_en,
    input  logic               ev_upd,
    input  logic               ev_cmp,
    input  logic [NUM_REF-1:0] oc_lvl,
    output logic [PRI_W-1:0]   cfg_pri_rd,
    output logic [SEC_W-1:0]   cfg_sec_rd,
    output logic               trig_pri,
    output logic               trig_sec
);

    logic [NUM_REF-1:0] rise_w, fall_w;
    evt_src_t           src_w;

    trgsel_cfg #(.HAS_SEC(HAS_SEC)) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cfg_wr),
        .pri_wdata (cfg_pri_wdata),
        .sec_wdata (cfg_sec_wdata),
        .pri_sel   (cfg_pri_rd),
        .sec_sel   (cfg_sec_rd)
    );

    trgsel_edge edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_in (oc_lvl),
        .rise   (rise_w),
        .fall   (fall_w)
    );

    always_comb begin
        src_w      = '0;
        src_w.ug   = ev_ug;
        src_w.en   = cnt_en;
        src_w.upd  = ev_upd;
        src_w.cmp  = ev_cmp;
        src_w.lvl  = oc_lvl;
        src_w.rise = rise_w;
        src_w.fall = fall_w;
    end

    trgsel_route #(.SEL_W(PRI_W)) pri_i (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (cfg_pri_rd),
        .src   (src_w),
        .trig  (trig_pri)
    );

    if (HAS_SEC) begin : g_sec
        trgsel_route #(.SEL_W(SEC_W)) sec_i (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (cfg_sec_rd),
            .src   (src_w),
            .trig  (trig_sec)
        );
    end else begin : g_nosec
        assign trig_sec = 1'b0;

        p_sec_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(oc_lvl[5]) |=> !trig_sec);
    end

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!trig_pri && !trig_sec && cfg_pri_rd == '0 && cfg_sec_rd == '0));

endmodule

// File: tb/trgsel_top_tb_top.sv
module trgsel_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_wr;
    logic [2:0] pw;
    logic [3:0] sw;
    logic       ev_ug, cnt_en, ev_upd, ev_cmp;
    logic [5:0] oc;

    logic [2:0] pri_rd, n_pri_rd;
    logic [3:0] sec_rd, n_sec_rd;
    logic       trig_pri, trig_sec, n_trig_pri, n_trig_sec;

    int n_tests = 0;
    int n_fail  = 0;
    int bpri    = 0;
    int bsec    = 0;
    logic [5:0] prev = '0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    trgsel_top #(.HAS_SEC(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_pri_wdata(pw), .cfg_sec_wdata(sw),
        .ev_ug(ev_ug), .cnt_en(cnt_en), .ev_upd(ev_upd), .ev_cmp(ev_cmp), .oc_lvl(oc),
        .cfg_pri_rd(pri_rd), .cfg_sec_rd(sec_rd), .trig_pri(trig_pri), .trig_sec(trig_sec)
    );

    trgsel_top #(.HAS_SEC(1'b0)) dut_nosec_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_pri_wdata(pw), .cfg_sec_wdata(sw),
        .ev_ug(ev_ug), .cnt_en(cnt_en), .ev_upd(ev_upd), .ev_cmp(ev_cmp), .oc_lvl(oc),
        .cfg_pri_rd(n_pri_rd), .cfg_sec_rd(n_sec_rd), .trig_pri(n_trig_pri), .trig_sec(n_trig_sec)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit pri_exp(input int c);
        case (c)
            0: return ev_ug;
            1: return cnt_en;
            2: return ev_upd;
            3: return ev_cmp;
            default: return oc[c-4];
        endcase
    endfunction

    function automatic bit sec_exp(input int c);
        bit r3, r4, r5, f3, f5;
        r3 = oc[3] & ~prev[3];
        r4 = oc[4] & ~prev[4];
        r5 = oc[5] & ~prev[5];
        f3 = ~oc[3] & prev[3];
        f5 = ~oc[5] & prev[5];
        case (c)
            8:  return oc[4];
            9:  return oc[5];
            10: return r3 | f3;
            11: return r5 | f5;
            12: return r3 | r5;
            13: return r3 | f5;
            14: return r4 | r5;
            15: return r4 | f5;
            default: return pri_exp(c);
        endcase
    endfunction

    function automatic string tag_pri(input int c);
        return (c < 4) ? "R2" : "R3";
    endfunction

    function automatic string tag_sec(input int c);
        if (c < 8)  return "R5";
        if (c < 10) return "R6";
        if (c < 12) return "R7";
        return "R8";
    endfunction

    // One clock: expectation from the inputs now applied, then compare after the edge.
    task automatic tick(input string ovr);
        bit ep, es;
        string tp, ts;
        ep = pri_exp(bpri);
        es = sec_exp(bsec);
        tp = (ovr.len() > 0) ? ovr : tag_pri(bpri);
        ts = (ovr.len() > 0) ? ovr : tag_sec(bsec);
        @(negedge clk);
        chk(trig_pri == ep, tp, int'(trig_pri), int'(ep));
        chk(trig_sec == es, ts, int'(trig_sec), int'(es));
        chk(n_trig_pri == ep, "R10", int'(n_trig_pri), int'(ep));
        chk(n_trig_sec == 1'b0 && n_sec_rd == 4'd0, "R10", int'(n_sec_rd) + int'(n_trig_sec), 0);
        prev = oc;
        if (cfg_wr) begin
            bpri = int'(pw);
            bsec = int'(sw);
        end
    endtask

    task automatic set_stim(input int v);
        ev_ug  = v[0];
        cnt_en = v[1];
        ev_upd = v[2];
        ev_cmp = v[3];
        oc     = 6'(v >> 4);
    endtask

    task automatic write_sel(input int c);
        cfg_wr = 1'b1;
        pw     = 3'(c);
        sw     = 4'(c);
        tick("");
        cfg_wr = 1'b0;
        chk(pri_rd == 3'(c), "R4", int'(pri_rd), c % 8);
        chk(sec_rd == 4'(c), "R4", int'(sec_rd), c);
        chk(n_pri_rd == 3'(c), "R4", int'(n_pri_rd), c % 8);
    endtask

    initial begin
        rst_n = 1'b0; cfg_wr = 1'b0; pw = '0; sw = '0;
        set_stim(0);
        repeat (3) @(negedge clk);
        chk(trig_pri == 1'b0 && trig_sec == 1'b0, "R1", int'(trig_pri) + int'(trig_sec), 0);
        chk(pri_rd == 3'd0 && sec_rd == 4'd0, "R1", int'(pri_rd) + int'(sec_rd), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(trig_pri == 1'b0 && trig_sec == 1'b0, "R1", int'(trig_pri) + int'(trig_sec), 0);

        // Sweep every code over an arithmetic pattern
        for (int c = 0; c < 16; c++) begin
            write_sel(c);
            for (int k = 0; k < 24; k++) begin
                set_stim(((k * 149 + c * 53) ^ (k << 3)) & 10'h3ff);
                tick("");
            end
        end

        // Held-level pulse width on every edge-derived code
        for (int c = 10; c < 16; c++) begin
            set_stim(0);
            write_sel(c);
            tick("R9");
            set_stim(10'h3f0);
            for (int k = 0; k < 4; k++) tick("R9");
            set_stim(0);
            for (int k = 0; k < 4; k++) tick("R9");
        end

        // Select field held when no write
        pw = 3'd2; sw = 4'd7;
        tick("R4");
        chk(pri_rd == 3'd7 && sec_rd == 4'd15, "R4", int'(pri_rd), 7);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule